// File: doc/BRIEF.md
# Trap Cause Arbiter for a Two-Level Sequential Core

This block decides, once per clock, whether a non-pipelined core has to leave its normal flow and enter a trap, and which cause code goes with that trap. It looks at three synchronous fault conditions of the instruction being checked:

- a fetch address whose two low bits are not zero;
- an opcode that the decoder flagged as unknown;
- a CSR access that is refused, either because the register does not exist or because the current privilege is too low for it.

It also looks at a bank of independent interrupt lines. Each line has its own enable bit, and one global enable gates the whole bank.

The block keeps the privilege state of the core, which is machine or user. When a trap is taken, it moves the core to machine mode and stores the privilege the core came from. It raises a "trap processing" flag that stays high until a return request arrives. A return restores the stored privilege. The core uses the one-cycle trap pulse and the registered cause code to start its trap states. The cause code is meant to be copied into the CSR file.

Top module: `trap_cause_ctrl`

## Requirements
- R1: After reset, `trap_take` and `in_trap` are 0, `trap_cause` is 0, and both `priv` and `prev_priv` hold the codes that reset gives them: `priv` is machine (2'b11) and `prev_priv` is user (2'b00).
- R2: With `insn_valid` high and `fetch_lsb` not equal to 2'b00, a trap is taken in the next cycle with cause code 0 (bit CAUSE_W-1 clear).
- R3: With `insn_valid` high and `opcode_bad` high, a trap is taken in the next cycle with cause code 2.
- R4: With `insn_valid` and `csr_access` high, a trap with cause code 3 is taken in the next cycle if either of two conditions holds. The first is that `csr_present` is low. The second is that the current privilege code (user 2'b00, machine 2'b11) is numerically below `csr_addr[9:8]`.
- R5: When several synchronous faults are present together, the cause is chosen as follows:
  - a misaligned fetch (code 0) wins over an unknown opcode (code 2);
  - an unknown opcode wins over a refused CSR access (code 3).
- R6: Pending lines with their enable bit set, with `global_ie` high and `in_trap` low, cause a trap in the next cycle. The cause has bit CAUSE_W-1 set and the index of the highest-numbered such line in the low bits.
- R7: The following produce no trap: an interrupt line whose enable bit is low, any interrupt while `global_ie` is low, and any interrupt while `in_trap` is high.
- R8: A synchronous fault in the same cycle as a qualifying interrupt wins, and its exception code is recorded with bit CAUSE_W-1 clear.
- R9: A taken trap works as follows:
  - `trap_take` is high for exactly the cycle after the request;
  - `priv` becomes machine;
  - `prev_priv` takes the privilege held before the trap;
  - `in_trap` goes high;
  - `trap_cause` holds its value until the next trap.
- R10: In machine mode, `trap_return` has these effects:
  - `priv` takes `prev_priv`;
  - `prev_priv` becomes user;
  - `in_trap` is cleared.

  In user mode, `trap_return` has no effect. In the same cycle as a trap request, the trap is taken and the return is dropped.
- R11: With `insn_valid` low, none of the fault inputs causes a trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | The fault inputs describe a real instruction this cycle |
| fetch_lsb | input | 2 | Two low bits of the fetch address |
| opcode_bad | input | 1 | Decoder did not recognise the opcode |
| csr_access | input | 1 | Instruction reads or writes a CSR |
| csr_addr | input | 12 | Address of the CSR being accessed |
| csr_present | input | 1 | The addressed CSR is implemented |
| irq_pend | input | NUM_IRQ | Interrupt lines |
| irq_en | input | NUM_IRQ | Per-line enable bits |
| global_ie | input | 1 | Global interrupt enable |
| trap_return | input | 1 | Return-from-trap request |
| trap_take | output | 1 | One-cycle pulse when a trap is taken |
| trap_cause | output | CAUSE_W | Interrupt flag in the top bit, cause number below it |
| in_trap | output | 1 | Core is processing a trap |
| priv | output | 2 | Current privilege code |
| prev_priv | output | 2 | Privilege saved at the last trap |

## Verification
The bench builds the block with its default values: 22 interrupt lines and a 32-bit cause. The interrupt sweep therefore reaches every line index, including the topmost line, in the highest-wins decision. The small fault space is covered exhaustively in both privilege modes:

- the four fetch alignments;
- opcode flag, CSR access and CSR presence;
- all four required-level codes.

This covers every priority pairing and every privilege comparison, including the two middle level codes. Nesting, interrupts blocked during trap processing, and a return that collides with a trap are driven on purpose.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam int EXC_FETCH_MISALIGN = 0;
  localparam int EXC_BAD_OPCODE     = 2;
  localparam int EXC_BAD_CSR        = 3;

  function automatic logic fetch_misaligned(input logic [1:0] lsb);
    return lsb != 2'b00;
  endfunction

  // required level sits in address bits [9:8]
  function automatic logic csr_denied(input logic [1:0] cur_priv,
                                      input logic [1:0] need_lvl,
                                      input logic       present);
    return !present || (cur_priv < need_lvl);
  endfunction
endpackage

// File: rtl/exc_filter.sv
module exc_filter
  import trap_pkg::*;
#(
  parameter int CODE_W = 31
) (
  input  logic              insn_valid,
  input  logic [1:0]        fetch_lsb,
  input  logic              opcode_bad,
  input  logic              csr_access,
  input  logic [1:0]        csr_lvl,
  input  logic              csr_present,
  input  logic [1:0]        cur_priv,
  output logic              exc_hit,
  output logic [CODE_W-1:0] exc_code
);
  logic misalign_ev, opcode_ev, csr_ev;

  assign misalign_ev = insn_valid && fetch_misaligned(fetch_lsb);
  assign opcode_ev   = insn_valid && opcode_bad;
  assign csr_ev      = insn_valid && csr_access && csr_denied(cur_priv, csr_lvl, csr_present);

  always_comb begin
    exc_hit  = 1'b1;
    exc_code = '0;
    if (misalign_ev)    exc_code = CODE_W'(EXC_FETCH_MISALIGN);
    else if (opcode_ev) exc_code = CODE_W'(EXC_BAD_OPCODE);
    else if (csr_ev)    exc_code = CODE_W'(EXC_BAD_CSR);
    else                exc_hit  = 1'b0;
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int NUM_IRQ = 22,
  parameter int IDX_W   = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] en,
  output logic               irq_hit,
  output logic [IDX_W-1:0]   irq_idx
);
  logic [NUM_IRQ-1:0] live;
  assign live = pend & en;

  // later (higher) index overrides earlier ones
  always_comb begin
    irq_hit = 1'b0;
    irq_idx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (live[i]) begin
        irq_hit = 1'b1;
        irq_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/priv_state.sv
module priv_state
  import trap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trap_req,
  input  logic       ret_req,
  output logic [1:0] priv,
  output logic [1:0] prev_priv,
  output logic       in_trap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv      <= PRIV_M;
      prev_priv <= PRIV_U;
      in_trap   <= 1'b0;
    end else if (trap_req) begin
      prev_priv <= priv;
      priv      <= PRIV_M;
      in_trap   <= 1'b1;
    end else if (ret_req) begin
      priv      <= prev_priv;
      prev_priv <= PRIV_U;
      in_trap   <= 1'b0;
    end
  end
endmodule

// File: rtl/trap_cause_ctrl.sv
module trap_cause_ctrl
  import trap_pkg::*;
#(
  parameter int NUM_IRQ = 22,
  parameter int CAUSE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               insn_valid,
  input  logic [1:0]         fetch_lsb,
  input  logic               opcode_bad,
  input  logic               csr_access,
  input  logic [11:0]        csr_addr,
  input  logic               csr_present,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               global_ie,
  input  logic               trap_return,
  output logic               trap_take,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic               in_trap,
  output logic [1:0]         priv,
  output logic [1:0]         prev_priv
);
  localparam int IDX_W  = $clog2(NUM_IRQ);
  localparam int CODE_W = CAUSE_W - 1;
  localparam int PAD_W  = CODE_W - IDX_W;

  logic              exc_hit, irq_hit, irq_ok, trap_req, ret_req;
  logic [CODE_W-1:0] exc_code;
  logic [IDX_W-1:0]  irq_idx;
  logic [CAUSE_W-1:0] cause_next;
  logic [9:0]        csr_addr_unused;

  assign csr_addr_unused = {csr_addr[11:10], csr_addr[7:0]};

  exc_filter #(.CODE_W(CODE_W)) u_exc (
    .insn_valid (insn_valid),
    .fetch_lsb  (fetch_lsb),
    .opcode_bad (opcode_bad),
    .csr_access (csr_access),
    .csr_lvl    (csr_addr[9:8]),
    .csr_present(csr_present),
    .cur_priv   (priv),
    .exc_hit    (exc_hit),
    .exc_code   (exc_code)
  );

  irq_prio #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_irq (
    .pend   (irq_pend),
    .en     (irq_en),
    .irq_hit(irq_hit),
    .irq_idx(irq_idx)
  );

  assign irq_ok   = irq_hit && global_ie && !in_trap;
  assign trap_req = exc_hit || irq_ok;
  assign ret_req  = trap_return && (priv == PRIV_M);

  assign cause_next = exc_hit ? {1'b0, exc_code}
                              : {1'b1, {PAD_W{1'b0}}, irq_idx};

  priv_state u_priv (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap_req (trap_req),
    .ret_req  (ret_req),
    .priv     (priv),
    .prev_priv(prev_priv),
    .in_trap  (in_trap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_take  <= 1'b0;
      trap_cause <= '0;
    end else begin
      trap_take <= trap_req;
      if (trap_req) trap_cause <= cause_next;
    end
  end
endmodule

// File: rtl/trap_cause_chk.sv
module trap_cause_chk #(
  parameter int CAUSE_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trap_take,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic               in_trap,
  input logic [1:0]         priv,
  input logic [1:0]         prev_priv,
  input logic               trap_req,
  input logic               exc_hit,
  input logic               ret_req,
  input logic               global_ie,
  input logic               insn_valid
);
  p_take_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> trap_take);
  p_take_only_on_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |=> !trap_take);
  p_machine_on_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |-> (priv == 2'b11) && in_trap);
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !exc_hit) |-> global_ie && !in_trap);
  p_exc_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && exc_hit) |=> !trap_cause[CAUSE_W-1]);
  p_no_exc_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |-> !exc_hit);
  p_return_restores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !trap_req) |=> !in_trap && (priv == $past(prev_priv)) && (prev_priv == 2'b00));
  p_priv_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'b00) || (priv == 2'b11));
  p_cause_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |=> $stable(trap_cause));
endmodule

bind trap_cause_ctrl trap_cause_chk #(.CAUSE_W(CAUSE_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .trap_take (trap_take),
  .trap_cause(trap_cause),
  .in_trap   (in_trap),
  .priv      (priv),
  .prev_priv (prev_priv),
  .trap_req  (trap_req),
  .exc_hit   (exc_hit),
  .ret_req   (ret_req),
  .global_ie (global_ie),
  .insn_valid(insn_valid)
);

// File: tb/trap_cause_ctrl_tb_top.sv
module trap_cause_ctrl_tb_top;
  localparam int N  = 22;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          insn_valid = 0, opcode_bad = 0, csr_access = 0, csr_present = 0;
  logic          global_ie = 0, trap_return = 0;
  logic [1:0]    fetch_lsb = 0;
  logic [11:0]   csr_addr = 0;
  logic [N-1:0]  irq_pend = 0, irq_en = 0;
  logic          trap_take, in_trap;
  logic [CW-1:0] trap_cause;
  logic [1:0]    priv, prev_priv;

  int checks = 0, errors = 0;
  logic [1:0]    m_priv = 2'b11, m_prev = 2'b00;
  logic          m_in = 0;
  logic [CW-1:0] m_cause = 0;

  always #2 clk = ~clk;

  trap_cause_ctrl #(.NUM_IRQ(N), .CAUSE_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .fetch_lsb(fetch_lsb),
    .opcode_bad(opcode_bad), .csr_access(csr_access), .csr_addr(csr_addr),
    .csr_present(csr_present), .irq_pend(irq_pend), .irq_en(irq_en),
    .global_ie(global_ie), .trap_return(trap_return), .trap_take(trap_take),
    .trap_cause(trap_cause), .in_trap(in_trap), .priv(priv), .prev_priv(prev_priv)
  );

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock of stimulus, then compare against the model
  task automatic cyc(input logic vld, input logic [1:0] lsb, input logic bad,
                     input logic csr, input logic [1:0] lvl, input logic pres,
                     input logic [N-1:0] pend, input logic [N-1:0] en,
                     input logic gie, input logic ret, input string tag);
    logic trap;
    logic [CW-1:0] cause;
    @(negedge clk);
    insn_valid = vld; fetch_lsb = lsb; opcode_bad = bad; csr_access = csr;
    csr_addr = {2'b01, lvl, 8'h5A}; csr_present = pres; irq_pend = pend;
    irq_en = en; global_ie = gie; trap_return = ret;
    trap = 1'b0; cause = '0;
    if (vld && lsb != 2'b00)                       begin trap = 1; cause = 0; end
    else if (vld && bad)                           begin trap = 1; cause = 2; end
    else if (vld && csr && (!pres || m_priv < lvl)) begin trap = 1; cause = 3; end
    else if (gie && !m_in) begin
      for (int i = 0; i < N; i++)
        if (pend[i] && en[i]) begin trap = 1; cause = {1'b1, 31'(i)}; end
    end
    if (trap) begin
      m_prev = m_priv; m_priv = 2'b11; m_in = 1; m_cause = cause;
    end else if (ret && m_priv == 2'b11) begin
      m_priv = m_prev; m_prev = 2'b00; m_in = 0;
    end
    @(posedge clk); #1;
    chk({tag, " take"},  CW'(trap_take), CW'(trap));
    chk({tag, " cause"}, trap_cause, m_cause);
    chk({tag, " in_trap"}, CW'(in_trap), CW'(m_in));
    chk({tag, " priv"},  CW'(priv), CW'(m_priv));
    chk({tag, " prev"},  CW'(prev_priv), CW'(m_prev));
    insn_valid = 0; opcode_bad = 0; csr_access = 0; irq_pend = 0;
    trap_return = 0; fetch_lsb = 0;
  endtask

  task automatic idle_ret(input string tag);
    cyc(0, 0, 0, 0, 0, 0, '0, '0, 0, 1, tag);
  endtask

  task automatic go_priv(input logic [1:0] tgt);
    for (int k = 0; k < 4 && m_priv != tgt; k++) begin
      if (tgt == 2'b00) idle_ret("R10");
      else cyc(1, 0, 1, 0, 0, 0, '0, '0, 0, 0, "R3");
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 take", CW'(trap_take), 0);
    chk("R1 in_trap", CW'(in_trap), 0);
    chk("R1 cause", trap_cause, 0);
    chk("R1 priv", CW'(priv), 3);
    chk("R1 prev", CW'(prev_priv), 0);

    // R2 R3 R4 R5 R11: full fault space in both privileges
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 256; c++) begin
        go_priv(p == 0 ? 2'b00 : 2'b11);
        cyc(c[7], c[1:0], c[2], c[3], c[5:4], c[6], '0, '0, 0, 0, "R2/R3/R4/R5/R11");
        if (m_in) idle_ret("R10");
      end
    end

    // R6: each single line from user mode
    for (int i = 0; i < N; i++) begin
      go_priv(2'b00);
      cyc(0, 0, 0, 0, 0, 0, N'(1) << i, N'(1) << i, 1, 0, "R6 single");
      idle_ret("R10");
    end
    // R6: all pending, enables limit the top line
    for (int i = 0; i < N; i++) begin
      cyc(0, 0, 0, 0, 0, 0, '1, (N'(1) << i) | N'(1), 1, 0, "R6 highest");
      idle_ret("R10");
    end
    // R7: masked line, global disable, busy in trap
    for (int i = 0; i < N; i++) begin
      cyc(0, 0, 0, 0, 0, 0, N'(1) << i, ~(N'(1) << i), 1, 0, "R7 masked");
      cyc(0, 0, 0, 0, 0, 0, N'(1) << i, '1, 0, 0, "R7 gie off");
    end
    go_priv(2'b00);
    cyc(1, 2'b10, 0, 0, 0, 0, '0, '0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, '1, '1, 1, 0, "R7 in trap");
    // nested fault during processing saves machine
    cyc(1, 0, 1, 0, 0, 0, '0, '0, 0, 0, "R9 nested");
    idle_ret("R10 back to machine");
    idle_ret("R10 back to user");
    idle_ret("R10 ignored in user");
    // R8: fault beats interrupt
    cyc(1, 0, 0, 1, 2'b11, 1, '1, '1, 1, 0, "R8");
    // R10: return collides with a trap request
    cyc(1, 2'b01, 0, 0, 0, 0, '0, '0, 0, 1, "R10 collide");
    idle_ret("R10");
    idle_ret("R10");
    // R9: back-to-back traps, cause held when idle
    cyc(0, 0, 0, 0, 0, 0, N'(1) << (N - 1), '1, 1, 0, "R9 top line");
    cyc(1, 0, 1, 0, 0, 0, '0, '0, 0, 0, "R9 back to back");
    cyc(0, 0, 0, 0, 0, 0, '0, '0, 0, 0, "R9 hold");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule